// File: doc/BRIEF.md
# Circulant Column Slice with Paged Operand and Result Storage

This block is one column slice of a matrix engine built as a ring of identical slices. Each slice owns one physical column of an N×N matrix laid out in circulant order: logical row r is rotated right by r places, so element (r, c) sits in slice (r + c) mod N at word r. With that layout every element of a logical column lies in a different slice. One shared base address then reaches a whole column in one cycle when each slice adds its own index, and a whole row in one cycle when no slice adds anything. Reading the stored matrix transposed is therefore only a change of the read mode.

The slice holds two pages of N words each. The page chosen by the page select is read as the operand. Incoming results are written to the other page in the same cycle. A sequencer flips the page select between operations, so a result becomes the next operand without being copied. Writes can use rotated or unrotated addressing; writing unrotated stores the transpose of a result column. A per-slice chip select gates both ports. Every other input is shared by all slices.

Top module: `circ_col_slice`

## Requirements
- R1: Reset is synchronous and active low. While it is held, and after it is released, `rd_word` is 0 until a new read completes. Reset does not alter stored words.
- R2: When `rd_rot` is 1, the slice reads word (`base_addr` + `slice_idx`) mod N of the operand page.
- R3: When `rd_rot` is 0, the slice reads word `base_addr` of the operand page and ignores `slice_idx`.
- R4: When `wr_rot` is 1, a write goes to word (`base_addr` + `slice_idx`) mod N of the result page.
- R5: When `wr_rot` is 0, a write goes to word `base_addr` of the result page and ignores `slice_idx`.
- R6: `page_sel` = 0 makes page 0 (storage words 0..N-1) the operand page and page 1 (words N..2N-1) the result page; `page_sel` = 1 swaps the two roles. A read and a write issued in the same cycle both take effect.
- R7: While `slice_sel` is 0, no word is written, even if `wr_en` is 1, and `rd_word` keeps its value.
- R8: A read issued in cycle t with `slice_sel` = 1 shows on `rd_word` after the second rising edge, and not after the first. A write issued in cycle t is visible to any read issued in cycle t+1 or later.
- R9: Take N = 3 and slice index 0. Write each column c in rotated mode with base (N - c) mod N, with each slice receiving element (r, c) for r = (base + index) mod N. A row-mode read of words 0, 1 and 2 then returns the elements (1,1), (2,3) and (3,2), in one-based numbering.
- R10: Rotated addressing wraps. If `base_addr` + `slice_idx` ≥ N, the word used is that sum minus N. For N = 3, base 2 and index 2 select word 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| base_addr | input | clog2(N) | Shared base word address, below N |
| slice_idx | input | clog2(N) | Static position of this slice in the ring, below N |
| rd_rot | input | 1 | Read addressing: 1 rotated (column access), 0 unrotated (row access) |
| wr_rot | input | 1 | Write addressing: 1 rotated, 0 unrotated (stores the transpose) |
| page_sel | input | 1 | Chooses which page is the operand; the other page takes writes |
| slice_sel | input | 1 | Per-slice enable for both read and write |
| wr_en | input | 1 | Write request for the result page |
| wr_word | input | DW | Data to be written |
| rd_word | output | DW | Word read from the operand page, two cycles after the request |

## Verification
The read of the operand page and the write of the result page happen in the same cycle, often with different address modes and different words. The bench provokes this by issuing rotated reads together with unrotated writes, and the reverse, at the same base address. A reference model of both pages predicts each read two cycles ahead. The stimulus then switches the page select and reads back the word just written. A correct slice returns the untouched operand word on the first read and the new data on the read-back; any leak between the pages, or any mixing of the two address modes, changes one of the two values.

// File: rtl/circ_col_pkg.sv
// Shared types for the circulant column slice.
// Assumes nothing beyond the users importing it.
package circ_col_pkg;

    // Address mode of a port: plain word index or index rotated by slice position
    typedef enum logic {
        ADDR_PLAIN = 1'b0,
        ADDR_ROT   = 1'b1
    } addr_mode_e;

    // Word offset of a page inside the 2N-word array
    function automatic int unsigned page_base(input logic page, input int unsigned n);
        return page ? n : 0;
    endfunction

endpackage

// File: rtl/circ_addr_wrap.sv
// Per-slice address generator: returns either the shared base address or the
// base plus the slice index, reduced modulo N by one conditional subtract.
// Assumes base < N and idx < N, so a single subtract always suffices.
module circ_addr_wrap
    import circ_col_pkg::*;
#(
    parameter int N  = 3,
    parameter int AW = $clog2(N)
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] idx,
    input  addr_mode_e    mode,
    output logic [AW-1:0] phys
);

    localparam logic [AW:0] N_EXT = (AW+1)'(N);

    logic [AW:0] sum;
    logic        over;

    // Rotated sum with a wrap flag; no divider is involved
    always_comb begin
        sum  = {1'b0, base} + {1'b0, idx};
        over = (sum >= N_EXT);
        if (mode == ADDR_ROT)
            phys = over ? AW'(sum - N_EXT) : AW'(sum);
        else
            phys = base;
    end

endmodule

// File: rtl/circ_bank_ram.sv
// Two-port word array with one write port and one registered read port.
// The array itself is not reset. The read register is cleared by the
// synchronous active-low reset. A read and a write to the same word at the
// same edge return the old word.
module circ_bank_ram #(
    parameter int DW    = 16,
    parameter int DEPTH = 6,
    parameter int FAW   = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [FAW-1:0] waddr,
    input  logic [DW-1:0]  wdata,
    input  logic           re,
    input  logic [FAW-1:0] raddr,
    output logic [DW-1:0]  rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write port: store one word when enabled
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Read port: register the addressed word when enabled, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/circ_col_slice.sv
// One column slice of a circulant matrix engine. Two address generators turn
// the shared base address into a read word and a write word: rotated by this
// slice's index, or unrotated. The operand page is picked by page_sel and the
// other page takes writes. Requests are registered once, and then the array
// port acts, giving two cycles of read latency.
// Assumes N >= 2, base_addr < N and slice_idx < N.
module circ_col_slice
    import circ_col_pkg::*;
#(
    parameter  int N   = 3,
    parameter  int DW  = 16,
    localparam int AW  = $clog2(N),
    localparam int FAW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] slice_idx,
    input  logic          rd_rot,
    input  logic          wr_rot,
    input  logic          page_sel,
    input  logic          slice_sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_word
);

    localparam int DEPTH = 2 * N;

    logic [AW-1:0]  rd_phys, wr_phys;
    logic [FAW-1:0] rd_full, wr_full;
    logic           rd_en_q, wr_en_q;
    logic [FAW-1:0] rd_addr_q, wr_addr_q;
    logic [DW-1:0]  wdata_q;

    circ_addr_wrap #(.N(N), .AW(AW)) u_rd_gen (
        .base (base_addr),
        .idx  (slice_idx),
        .mode (addr_mode_e'(rd_rot)),
        .phys (rd_phys)
    );

    circ_addr_wrap #(.N(N), .AW(AW)) u_wr_gen (
        .base (base_addr),
        .idx  (slice_idx),
        .mode (addr_mode_e'(wr_rot)),
        .phys (wr_phys)
    );

    // Place each word inside its page: operand page for reads, the other page for writes
    always_comb begin
        rd_full = FAW'(rd_phys) + FAW'(page_base(page_sel, N));
        wr_full = FAW'(wr_phys) + FAW'(page_base(~page_sel, N));
    end

    // Request stage: capture gated enables, full addresses and write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_en_q   <= 1'b0;
            wr_en_q   <= 1'b0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            wdata_q   <= '0;
        end else begin
            rd_en_q   <= slice_sel;
            wr_en_q   <= slice_sel & wr_en;
            rd_addr_q <= rd_full;
            wr_addr_q <= wr_full;
            wdata_q   <= wr_word;
        end
    end

    circ_bank_ram #(.DW(DW), .DEPTH(DEPTH), .FAW(FAW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en_q),
        .waddr (wr_addr_q),
        .wdata (wdata_q),
        .re    (rd_en_q),
        .raddr (rd_addr_q),
        .rdata (rd_word)
    );

endmodule

// File: rtl/circ_col_slice_chk.sv
// Property checker for circ_col_slice, attached by the bind below. It relates
// the port requests to the registered request stage and to the read word.
module circ_col_slice_chk #(
    parameter  int N   = 3,
    parameter  int DW  = 16,
    localparam int AW  = $clog2(N),
    localparam int FAW = AW + 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  base_addr,
    input logic [AW-1:0]  slice_idx,
    input logic           rd_rot,
    input logic           page_sel,
    input logic           slice_sel,
    input logic           wr_en,
    input logic [DW-1:0]  rd_word,
    input logic           rd_en_q,
    input logic           wr_en_q,
    input logic [FAW-1:0] rd_addr_q,
    input logic [FAW-1:0] wr_addr_q
);

    // R2 and R10: a rotated read lands on (base + index) mod N
    a_r2_rot_read: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_sel && rd_rot) |=> (rd_en_q &&
            ((int'(rd_addr_q) % N) == ((int'($past(base_addr)) + int'($past(slice_idx))) % N))));

    // R3: a plain read lands on the base address
    a_r3_plain_read: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_sel && !rd_rot) |=> ((int'(rd_addr_q) % N) == int'($past(base_addr))));

    // R6: reads stay inside the operand page
    a_r6_read_page: assert property (@(posedge clk) disable iff (!rst_n)
        slice_sel |=> ((int'(rd_addr_q) >= N) == $past(page_sel)));

    // R6: writes land in the page that is not the operand page
    a_r6_write_page: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_sel && wr_en) |=> (wr_en_q && ((int'(wr_addr_q) >= N) != $past(page_sel))));

    // R7: a deselected slice issues no access
    a_r7_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        !slice_sel |=> (!rd_en_q && !wr_en_q));

    // R7 and R8: the read word moves only when a request reaches the array
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_q |=> $stable(rd_word));

endmodule

bind circ_col_slice circ_col_slice_chk #(.N(N), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_addr (base_addr),
    .slice_idx (slice_idx),
    .rd_rot    (rd_rot),
    .page_sel  (page_sel),
    .slice_sel (slice_sel),
    .wr_en     (wr_en),
    .rd_word   (rd_word),
    .rd_en_q   (rd_en_q),
    .wr_en_q   (wr_en_q),
    .rd_addr_q (rd_addr_q),
    .wr_addr_q (wr_addr_q)
);

// File: tb/circ_col_slice_bench.sv
// Bench for circ_col_slice with N = 3. A model of both pages predicts each
// read, and the bench compares that prediction with rd_word two cycles later.
// A vector table is walked first. Directed tests for reset, layout and latency follow.
`timescale 1ns/1ps
module circ_col_slice_bench;

    localparam int N  = 3;
    localparam int DW = 16;
    localparam int AW = $clog2(N);
    localparam int VW = 2*AW + 5 + DW + 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] base_addr, slice_idx;
    logic          rd_rot, wr_rot, page_sel, slice_sel, wr_en;
    logic [DW-1:0] wr_word, rd_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    logic [DW-1:0] m_mem [2*N];
    bit            m_known [2*N];
    logic [DW-1:0] p_val [2];
    bit            p_chk [2];
    int            p_tag [2];
    logic [DW-1:0] last_val;
    bit            last_known;

    always #4 clk = ~clk;

    circ_col_slice #(.N(N), .DW(DW)) u_circ_col_slice (
        .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .slice_idx(slice_idx),
        .rd_rot(rd_rot), .wr_rot(wr_rot), .page_sel(page_sel), .slice_sel(slice_sel),
        .wr_en(wr_en), .wr_word(wr_word), .rd_word(rd_word)
    );

    function automatic logic [VW-1:0] vec(input int b, input int i, input bit rr, input bit wrr,
                                          input bit pg, input bit cs, input bit we,
                                          input logic [DW-1:0] d, input int tag);
        return {AW'(b), AW'(i), rr, wrr, pg, cs, we, d, 4'(tag)};
    endfunction

    // table: base, idx, rd_rot, wr_rot, page_sel, slice_sel, wr_en, data, requirement
    localparam logic [VW-1:0] TBL [16] = '{
        vec(0,0,1,0,0,1,0,16'h0000, 2),   // R2 rotated read word 0
        vec(1,1,1,0,0,1,0,16'h0000, 2),   // R2 rotated read word 2
        vec(2,2,1,0,0,1,0,16'h0000,10),   // R10 wrap to word 1
        vec(2,1,1,0,1,1,0,16'h0000,10),   // R10 wrap to word 0, page 1
        vec(2,1,0,0,1,1,0,16'h0000, 3),   // R3 plain read ignores index
        vec(1,2,0,0,0,1,0,16'h0000, 3),   // R3 plain read page 0
        vec(1,1,1,1,0,1,1,16'h5501, 6),   // R6 read page 0 while writing page 1
        vec(1,1,1,0,1,1,0,16'h0000, 4),   // R4 read back rotated write
        vec(0,2,0,0,1,1,1,16'h6602, 6),   // R6 plain write page 0, read page 1
        vec(0,0,0,0,0,1,0,16'h0000, 5),   // R5 plain write ignored index
        vec(0,0,0,0,0,0,1,16'hDEAD, 7),   // R7 deselected write
        vec(0,0,0,0,1,1,0,16'h0000, 7),   // R7 word still unchanged
        vec(2,2,1,0,0,0,0,16'h0000, 7),   // R7 deselected read holds
        vec(2,2,0,1,1,1,1,16'h7703, 6),   // R6 rotated write page 0, plain read page 1
        vec(0,1,1,0,0,1,0,16'h0000, 4),   // R4 read back wrapped write
        vec(0,0,0,0,0,0,0,16'h0000, 8)    // idle
    };

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input int tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic clear_model_pipe();
        p_chk[0] = 1'b0; p_chk[1] = 1'b0;
        last_val = '0; last_known = 1'b1;
    endtask

    // one cycle: check the prediction due now, drive the request, update the model
    task automatic step(input int b, input int i, input bit rr, input bit wrr, input bit pg,
                        input bit cs, input bit we, input logic [DW-1:0] d, input int tag);
        int ra, wa;
        logic [DW-1:0] pv;
        bit pk;
        @(negedge clk);
        if (p_chk[1]) check(rd_word, p_val[1], p_tag[1], "scoreboard read");
        base_addr = AW'(b); slice_idx = AW'(i); rd_rot = rr; wr_rot = wrr;
        page_sel = pg; slice_sel = cs; wr_en = we; wr_word = d;
        ra = (rr ? (b + i) % N : b) + (pg ? N : 0);
        wa = (wrr ? (b + i) % N : b) + (pg ? 0 : N);
        if (cs) begin pv = m_mem[ra]; pk = m_known[ra]; end
        else    begin pv = last_val;  pk = last_known;  end
        last_val = pv; last_known = pk;
        if (cs && we) begin m_mem[wa] = d; m_known[wa] = 1'b1; end
        p_val[1] = p_val[0]; p_chk[1] = p_chk[0]; p_tag[1] = p_tag[0];
        p_val[0] = pv;       p_chk[0] = pk;       p_tag[0] = tag;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, '0, 8);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 2*N; k++) begin m_mem[k] = '0; m_known[k] = 1'b0; end
        clear_model_pipe();
        rst_n = 1'b0; base_addr = '0; slice_idx = '0; rd_rot = 1'b0; wr_rot = 1'b0;
        page_sel = 1'b0; slice_sel = 1'b0; wr_en = 1'b0; wr_word = '0;
        repeat (3) @(negedge clk);
        check(rd_word, '0, 1, "read word during reset");            // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_word, '0, 1, "read word after reset release");     // R1

        // preload both pages with plain writes (reads unknown, not checked)
        for (int a = 0; a < N; a++) step(a, 0, 0, 0, 1, 1, 1, 16'h00B0 | 16'(a), 5);
        for (int a = 0; a < N; a++) step(a, 0, 0, 0, 0, 1, 1, 16'h00C0 | 16'(a), 5);

        // table walk
        for (int s = 0; s < 16; s++) begin
            logic [VW-1:0] v;
            v = TBL[s];
            step(int'(v[VW-1 -: AW]), int'(v[VW-AW-1 -: AW]), v[DW+8], v[DW+7], v[DW+6],
                 v[DW+5], v[DW+4], v[DW+3:4], int'(v[3:0]));
        end
        idle(); idle();

        // R1: reset mid-run clears the read word but keeps stored words
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rd_word, '0, 1, "read word after mid-run reset");
        rst_n = 1'b1;
        clear_model_pipe();
        step(0, 0, 0, 0, 1, 1, 0, '0, 1);   // R1 page 1 word 0 survives reset
        idle(); idle();

        // R9: circulant layout of a 3x3 matrix in slice 0
        for (int c = 0; c < N; c++) begin
            int b;
            b = (N - c) % N;
            step(b, 0, 0, 1, 1, 1, 1, 16'(16 * (b + 1) + (c + 1)), 9);
        end
        step(0, 0, 0, 0, 0, 1, 0, '0, 9);
        step(1, 0, 0, 0, 0, 1, 0, '0, 9);
        step(2, 0, 0, 0, 0, 1, 0, '0, 9);
        check(rd_word, 16'h0011, 9, "layout word 0");
        step(0, 0, 0, 0, 0, 0, 0, '0, 9);
        check(rd_word, 16'h0023, 9, "layout word 1");
        step(0, 0, 0, 0, 0, 0, 0, '0, 9);
        check(rd_word, 16'h0032, 9, "layout word 2");

        // R8: exact two-cycle read latency
        step(1, 0, 0, 0, 0, 1, 0, '0, 8);   // read 0x23 while 0x32 shows
        idle();
        check(rd_word, 16'h0032, 8, "one cycle after read request");
        idle();
        check(rd_word, 16'h0023, 8, "two cycles after read request");
        idle(); idle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule